// File: doc/BRIEF.md
# Bound Register Move Unit

This block keeps a small file of bound registers. Each entry pairs a lower bound with an upper bound. The block executes the bound-move instructions that copy a pair between two registers, load a pair from memory, or store a pair to memory. Instructions arrive already decoded, one per valid/ready handshake. Each one carries the opcode byte, the ModRM fields, the REX extension bits, the lock, operand-size and address-size prefix flags, the mode flags, the privilege level, the alignment-check enable and a precomputed effective address. Every accepted instruction ends with exactly one single-cycle completion pulse, which reports whether it faulted and how.

Memory traffic goes through a single-beat request channel. The request channel uses valid/ready. Once `mreq_valid` is high, the block holds it and every request field stable until `mreq_ready` is sampled high at a clock edge, so the memory side may stall for any number of cycles. Load data comes back on a response strobe with no back-pressure. The block takes the response only while a load is outstanding, and ignores it at all other times.

While an instruction is in flight, `in_ready` stays low. It rises again only after the completion cycle. The layout of the pair in memory depends on the mode:
- In 64-bit mode the pair is two full 64-bit words.
- Otherwise the pair is two 32-bit words, which are zero-extended when loaded.

Top module: `bnd_move_unit`

## Requirements
- R1: After reset, every bound register reads as zero, `in_ready` is high, and `mreq_valid` and `done_valid` are low.
- R2: Opcode 0x1A with the operand-size prefix moves a pair into the register named by the reg field. Opcode 0x1B with the prefix moves the reg-field register's pair out. Any other opcode, or a missing prefix, completes with `done_ud`=1.
- R3: When mod=3, the pair is copied between registers: lower bound to lower bound, upper bound to upper bound. No memory request is issued.
- R4: In 64-bit mode a load issues one read with `mreq_be`=0xFFFF at the effective address. The lower bound is taken from response bits [63:0] and the upper bound from bits [127:64].
- R5: In 64-bit mode a store issues one write with `mreq_be`=0xFFFF. `mreq_wdata`[63:0] carries the lower bound and [127:64] carries the upper bound.
- R6: Outside 64-bit mode a load issues a read with `mreq_be`=0x00FF. The lower bound becomes the zero-extended response bits [31:0], and the upper bound becomes the zero-extended bits [63:32].
- R7: Outside 64-bit mode a store writes the low 32 bits of the lower bound to [31:0] and the low 32 bits of the upper bound to [63:32]. Bits [127:64] are zero and `mreq_be`=0x00FF.
- R8: With the lock prefix, an instruction faults with `done_ud` whenever its destination is not memory (all 0x1A forms, and 0x1B with mod=3). A locked 0x1B store to memory proceeds normally.
- R9: A register index of 4 or higher gives `done_ud`. In 64-bit mode the index is formed as {REX bit, 3-bit field}; outside 64-bit mode it is the 3-bit field alone. The check applies to the reg field, and also to the r/m field when mod=3.
- R10: Outside 64-bit mode, 16-bit addressing gives `done_ud`. This is the case when the address-size prefix flag equals `in_cs_d`.
- R11: A memory form gives `done_ac` when alignment checking is enabled, CPL=3 and the effective address is not a multiple of the transfer size (16 bytes in 64-bit mode, 8 otherwise). An invalid-opcode fault takes precedence, and `done_ud` and `done_ac` are never both set.
- R12: A faulting instruction issues no memory request and writes no register. It finishes with a single-cycle `done_valid`.
- R13: While `mreq_valid` is high and `mreq_ready` is low, the request and all its fields stay unchanged. `in_ready` stays low from acceptance through the completion cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, instruction accepted on this edge |
| in_opcode | input | 8 | Second opcode byte after 0x0F |
| in_opsz_pfx | input | 1 | Operand-size (0x66) prefix present |
| in_lock_pfx | input | 1 | Lock prefix present |
| in_addr_pfx | input | 1 | Address-size prefix present |
| in_mode64 | input | 1 | Executing in 64-bit mode |
| in_cs_d | input | 1 | Code-segment default-size bit |
| in_cpl | input | 2 | Current privilege level |
| in_ac_en | input | 1 | Alignment checking enabled |
| in_mod | input | 2 | ModRM mod field |
| in_reg | input | 3 | ModRM reg field |
| in_rm | input | 3 | ModRM r/m field |
| in_rex_r | input | 1 | REX extension of reg |
| in_rex_b | input | 1 | REX extension of r/m |
| in_ea | input | ADDR_W | Effective address of the memory operand |
| mreq_valid | output | 1 | Memory request pending |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_we | output | 1 | 1 = write, 0 = read |
| mreq_addr | output | ADDR_W | Request address |
| mreq_be | output | 2*BND_W/8 | Byte enables |
| mreq_wdata | output | 2*BND_W | Write data |
| mrsp_valid | input | 1 | Read data valid |
| mrsp_data | input | 2*BND_W | Read data |
| done_valid | output | 1 | Instruction completed (one cycle) |
| done_ud | output | 1 | Completed with invalid-opcode fault |
| done_ac | output | 1 | Completed with alignment fault |

## Verification
The bench targets several corner cases, and each one would show up at the ports if the design got it wrong:
- **Zero extension of legacy loads.** It loads a legacy-mode pair whose upper response half is all ones. A design that skips the zero extension would store those ones back out.
- **Lock-prefix handling.** It checks both sides of the lock rule. A design that faulted every locked form would reject a legacy store to memory; one that ignored the prefix would let a locked register copy through.
- **REX-extended indices.** It drives an r/m index extended to 8 by REX. A design that dropped the REX bit would copy from register 0 instead of faulting.
- **Fault precedence.** It drives a misaligned address that also carries a lock fault. This shows whether both fault flags can be raised at once.
- **No side effects from faults.** It reads register 0 back after a faulting load aimed at it. A design that writes on a fault would return the junk response data.
- **Memory back-pressure.** A multi-cycle stall on `mreq_ready` exposes request fields that drift, or an `in_ready` that reopens early.

// File: rtl/bnd_move_pkg.sv
package bnd_move_pkg;

  localparam logic [7:0] OPC_BND_LOAD  = 8'h1A;
  localparam logic [7:0] OPC_BND_STORE = 8'h1B;
  localparam logic [1:0] MOD_REGREG    = 2'b11;
  localparam logic [1:0] CPL_USER      = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_DONE
  } mv_state_e;

  typedef struct packed {
    logic       into_reg;   // 0x1A: destination is the reg-field register
    logic       mem_form;   // mod != 3
    logic       fault_ud;
    logic       fault_ac;
    logic [3:0] reg_ix;     // extended reg index
    logic [3:0] rm_ix;      // extended r/m index
  } dec_out_t;

endpackage

// File: rtl/bnd_decode.sv
module bnd_decode
  import bnd_move_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic [7:0] opcode,
  input  logic       opsz_pfx,
  input  logic       lock_pfx,
  input  logic       addr_pfx,
  input  logic       mode64,
  input  logic       cs_d,
  input  logic [1:0] cpl,
  input  logic       ac_en,
  input  logic [1:0] modf,
  input  logic [2:0] regf,
  input  logic [2:0] rmf,
  input  logic       rex_r,
  input  logic       rex_b,
  input  logic [3:0] ea_lo,
  output dec_out_t   dec
);

  logic opc_known, is_load, is_mem;
  logic ud_opc, ud_lock, ud_index, ud_addr16, ud_any;
  logic misaligned;
  logic [3:0] reg_ix, rm_ix;

  always_comb begin
    is_load   = (opcode == OPC_BND_LOAD);
    opc_known = opsz_pfx && (is_load || opcode == OPC_BND_STORE);
    is_mem    = (modf != MOD_REGREG);

    // REX bits only extend the index in 64-bit mode
    reg_ix = {mode64 & rex_r, regf};
    rm_ix  = {mode64 & rex_b, rmf};

    ud_opc    = !opc_known;
    ud_lock   = lock_pfx && (is_load || !is_mem);
    ud_index  = (32'(reg_ix) >= NREG) || (!is_mem && (32'(rm_ix) >= NREG));
    ud_addr16 = !mode64 && (addr_pfx == cs_d);
    ud_any    = ud_opc || ud_lock || ud_index || ud_addr16;

    misaligned = mode64 ? (|ea_lo) : (|ea_lo[2:0]);

    dec.into_reg = is_load;
    dec.mem_form = is_mem;
    dec.fault_ud = ud_any;
    dec.fault_ac = !ud_any && is_mem && ac_en && (cpl == CPL_USER) && misaligned;
    dec.reg_ix   = reg_ix;
    dec.rm_ix    = rm_ix;
  end

endmodule

// File: rtl/bnd_regfile.sv
module bnd_regfile #(
  parameter int NREG  = 4,
  parameter int BND_W = 64,
  localparam int PAIR_W = 2 * BND_W,
  localparam int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PAIR_W-1:0] wr_pair,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PAIR_W-1:0] rd_pair
);

  logic [PAIR_W-1:0] entry_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry_q[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        entry_q[g] <= wr_pair;
    end
  end

  assign rd_pair = entry_q[rd_idx];

endmodule

// File: rtl/bnd_mem_fmt.sv
module bnd_mem_fmt #(
  parameter int BND_W = 64,
  localparam int PAIR_W = 2 * BND_W,
  localparam int HALF_W = BND_W / 2,
  localparam int NBYTES = PAIR_W / 8
) (
  input  logic              mode64,
  input  logic [PAIR_W-1:0] st_pair,   // {upper, lower}
  input  logic [PAIR_W-1:0] ld_data,
  output logic [PAIR_W-1:0] st_data,
  output logic [NBYTES-1:0] be,
  output logic [PAIR_W-1:0] ld_pair    // {upper, lower}
);

  logic [BND_W-1:0] st_lo, st_hi;

  always_comb begin
    st_lo = st_pair[BND_W-1:0];
    st_hi = st_pair[PAIR_W-1:BND_W];
    if (mode64) begin
      st_data = {st_hi, st_lo};
      be      = '1;
      ld_pair = ld_data;
    end else begin
      st_data = {{BND_W{1'b0}}, st_hi[HALF_W-1:0], st_lo[HALF_W-1:0]};
      be      = {{(NBYTES/2){1'b0}}, {(NBYTES/2){1'b1}}};
      ld_pair = {{HALF_W{1'b0}}, ld_data[BND_W-1:HALF_W],
                 {HALF_W{1'b0}}, ld_data[HALF_W-1:0]};
    end
  end

endmodule

// File: rtl/bnd_move_unit.sv
module bnd_move_unit
  import bnd_move_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int BND_W  = 64,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_opcode,
  input  logic                    in_opsz_pfx,
  input  logic                    in_lock_pfx,
  input  logic                    in_addr_pfx,
  input  logic                    in_mode64,
  input  logic                    in_cs_d,
  input  logic [1:0]              in_cpl,
  input  logic                    in_ac_en,
  input  logic [1:0]              in_mod,
  input  logic [2:0]              in_reg,
  input  logic [2:0]              in_rm,
  input  logic                    in_rex_r,
  input  logic                    in_rex_b,
  input  logic [ADDR_W-1:0]       in_ea,
  output logic                    mreq_valid,
  input  logic                    mreq_ready,
  output logic                    mreq_we,
  output logic [ADDR_W-1:0]       mreq_addr,
  output logic [2*BND_W/8-1:0]    mreq_be,
  output logic [2*BND_W-1:0]      mreq_wdata,
  input  logic                    mrsp_valid,
  input  logic [2*BND_W-1:0]      mrsp_data,
  output logic                    done_valid,
  output logic                    done_ud,
  output logic                    done_ac
);

  localparam int PAIR_W = 2 * BND_W;
  localparam int NBYTES = PAIR_W / 8;
  localparam int IDX_W  = $clog2(NREG);

  mv_state_e         state_q;
  dec_out_t          dec;
  logic              accept, dec_clean;
  logic [IDX_W-1:0]  rd_idx, wr_idx, lat_idx_q;
  logic [PAIR_W-1:0] rd_pair, wr_pair, fmt_st_data, fmt_ld_pair;
  logic [NBYTES-1:0] fmt_be;
  logic              wr_en, fmt_mode, lat_m64_q;
  logic              lat_we_q, lat_ud_q, lat_ac_q;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [NBYTES-1:0] lat_be_q;
  logic [PAIR_W-1:0] lat_wdata_q;

  bnd_decode #(.NREG(NREG)) u_decode (
    .opcode   (in_opcode),
    .opsz_pfx (in_opsz_pfx),
    .lock_pfx (in_lock_pfx),
    .addr_pfx (in_addr_pfx),
    .mode64   (in_mode64),
    .cs_d     (in_cs_d),
    .cpl      (in_cpl),
    .ac_en    (in_ac_en),
    .modf     (in_mod),
    .regf     (in_reg),
    .rmf      (in_rm),
    .rex_r    (in_rex_r),
    .rex_b    (in_rex_b),
    .ea_lo    (in_ea[3:0]),
    .dec      (dec)
  );

  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign dec_clean = !dec.fault_ud && !dec.fault_ac;

  // Source of a copy: r/m for 0x1A, reg for 0x1B (also the store source)
  assign rd_idx = (dec.into_reg && !dec.mem_form) ? dec.rm_ix[IDX_W-1:0]
                                                  : dec.reg_ix[IDX_W-1:0];

  // Formatting follows the incoming mode at accept, latched mode afterwards
  assign fmt_mode = (state_q == ST_IDLE) ? in_mode64 : lat_m64_q;

  bnd_mem_fmt #(.BND_W(BND_W)) u_fmt (
    .mode64  (fmt_mode),
    .st_pair (rd_pair),
    .ld_data (mrsp_data),
    .st_data (fmt_st_data),
    .be      (fmt_be),
    .ld_pair (fmt_ld_pair)
  );

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = lat_idx_q;
    wr_pair = fmt_ld_pair;
    if (accept && dec_clean && !dec.mem_form) begin
      wr_en   = 1'b1;
      wr_idx  = dec.into_reg ? dec.reg_ix[IDX_W-1:0] : dec.rm_ix[IDX_W-1:0];
      wr_pair = rd_pair;
    end else if (state_q == ST_RSP && mrsp_valid) begin
      wr_en   = 1'b1;
    end
  end

  bnd_regfile #(.NREG(NREG), .BND_W(BND_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_pair (wr_pair),
    .rd_idx  (rd_idx),
    .rd_pair (rd_pair)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      lat_m64_q   <= 1'b0;
      lat_we_q    <= 1'b0;
      lat_ud_q    <= 1'b0;
      lat_ac_q    <= 1'b0;
      lat_idx_q   <= '0;
      lat_addr_q  <= '0;
      lat_be_q    <= '0;
      lat_wdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          lat_ud_q    <= dec.fault_ud;
          lat_ac_q    <= dec.fault_ac;
          lat_m64_q   <= in_mode64;
          lat_we_q    <= !dec.into_reg;
          lat_idx_q   <= dec.reg_ix[IDX_W-1:0];
          lat_addr_q  <= in_ea;
          lat_be_q    <= fmt_be;
          lat_wdata_q <= dec.into_reg ? '0 : fmt_st_data;
          state_q     <= (dec_clean && dec.mem_form) ? ST_REQ : ST_DONE;
        end
        ST_REQ: if (mreq_ready)
          state_q <= lat_we_q ? ST_DONE : ST_RSP;
        ST_RSP: if (mrsp_valid)
          state_q <= ST_DONE;
        default: begin
          lat_ud_q <= 1'b0;
          lat_ac_q <= 1'b0;
          state_q  <= ST_IDLE;
        end
      endcase
    end
  end

  assign mreq_valid = (state_q == ST_REQ);
  assign mreq_we    = lat_we_q;
  assign mreq_addr  = lat_addr_q;
  assign mreq_be    = lat_be_q;
  assign mreq_wdata = lat_wdata_q;
  assign done_valid = (state_q == ST_DONE);
  assign done_ud    = done_valid && lat_ud_q;
  assign done_ac    = done_valid && lat_ac_q;

endmodule

// File: rtl/bnd_move_chk.sv
module bnd_move_chk #(
  parameter int BND_W  = 64,
  parameter int ADDR_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_ready,
  input logic                 mreq_valid,
  input logic                 mreq_ready,
  input logic                 mreq_we,
  input logic [ADDR_W-1:0]    mreq_addr,
  input logic [2*BND_W/8-1:0] mreq_be,
  input logic [2*BND_W-1:0]   mreq_wdata,
  input logic                 done_valid,
  input logic                 done_ud,
  input logic                 done_ac
);

  localparam int NBYTES = 2 * BND_W / 8;

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr) &&
      $stable(mreq_we) && $stable(mreq_be) && $stable(mreq_wdata)));

  assert_busy_no_accept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid || done_valid) |-> !in_ready);

  assert_fault_no_mem_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && (done_ud || done_ac)) |-> !$past(mreq_valid));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  assert_fault_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ud && done_ac));

  assert_fault_only_at_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done_valid |-> (!done_ud && !done_ac));

  assert_be_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> ((mreq_be == {NBYTES{1'b1}}) ||
                    (mreq_be == {{(NBYTES/2){1'b0}}, {(NBYTES/2){1'b1}}})));

endmodule

bind bnd_move_unit bnd_move_chk #(.BND_W(BND_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .mreq_valid (mreq_valid),
  .mreq_ready (mreq_ready),
  .mreq_we    (mreq_we),
  .mreq_addr  (mreq_addr),
  .mreq_be    (mreq_be),
  .mreq_wdata (mreq_wdata),
  .done_valid (done_valid),
  .done_ud    (done_ud),
  .done_ac    (done_ac)
);

// File: tb/bnd_move_unit_tb_top.sv
module bnd_move_unit_tb_top;

  localparam int NV = 23;

  typedef struct packed {
    logic [7:0]   op;
    logic         p66;
    logic         lock;
    logic         asz;
    logic         m64;
    logic         csd;
    logic [1:0]   cpl;
    logic         acen;
    logic [1:0]   md;
    logic [2:0]   rg;
    logic [2:0]   rm;
    logic         rexr;
    logic         rexb;
    logic [15:0]  ea;
    logic [127:0] rdata;
    logic         e_ud;
    logic         e_ac;
    logic         e_req;
    logic         e_we;
    logic [15:0]  e_be;
    logic [127:0] e_wd;
  } vec_t;

  localparam logic [127:0] D0 = 128'h1111_2222_3333_4444_AAAA_BBBB_CCCC_DDDD;
  localparam logic [127:0] D1 = 128'hFFFF_FFFF_FFFF_FFFF_89AB_CDEF_0123_4567;
  localparam logic [127:0] D2 = 128'h0000_0000_89AB_CDEF_0000_0000_0123_4567;
  localparam logic [127:0] D3 = 128'h5555_5555_6666_6666_7777_7777_8888_8888;
  localparam logic [127:0] DL = 128'h0000_0000_0000_0000_3333_4444_CCCC_DDDD;
  localparam logic [127:0] DJ = 128'hDEAD_DEAD_DEAD_DEAD_BEEF_BEEF_BEEF_BEEF;
  localparam logic [127:0] Z  = 128'h0;

  //  op    66 lk as 64 cd cpl ac md rg rm xr xb ea        rdata ud ac rq we be        wd
  localparam vec_t VECS [NV] = '{
    '{8'h1A,1,0,0,1,0,2'd0,0,2'd0,3'd0,3'd0,0,0,16'h0100,D0, 0,0,1,0,16'hFFFF,Z },  // 0 R4
    '{8'h1B,1,0,0,1,0,2'd0,0,2'd0,3'd0,3'd0,0,0,16'h0200,Z,  0,0,1,1,16'hFFFF,D0},  // 1 R5
    '{8'h1A,1,0,0,1,0,2'd0,0,2'd3,3'd1,3'd0,0,0,16'h0000,Z,  0,0,0,0,16'h0000,Z },  // 2 R3
    '{8'h1B,1,0,0,1,0,2'd0,0,2'd0,3'd1,3'd0,0,0,16'h0210,Z,  0,0,1,1,16'hFFFF,D0},  // 3 R3
    '{8'h1A,1,0,0,0,1,2'd0,0,2'd0,3'd2,3'd0,0,0,16'h0300,D1, 0,0,1,0,16'h00FF,Z },  // 4 R6
    '{8'h1B,1,0,0,1,0,2'd0,0,2'd0,3'd2,3'd0,0,0,16'h0220,Z,  0,0,1,1,16'hFFFF,D2},  // 5 R6
    '{8'h1B,1,0,1,0,0,2'd3,1,2'd0,3'd0,3'd0,0,0,16'h0408,Z,  0,0,1,1,16'h00FF,DL},  // 6 R7
    '{8'h1B,1,1,0,1,0,2'd0,0,2'd3,3'd0,3'd1,0,0,16'h0000,Z,  1,0,0,0,16'h0000,Z },  // 7 R8
    '{8'h1A,1,1,0,1,0,2'd0,0,2'd0,3'd0,3'd0,0,0,16'h0110,DJ, 1,0,0,0,16'h0000,Z },  // 8 R8
    '{8'h1B,1,1,1,0,0,2'd0,0,2'd0,3'd1,3'd0,0,0,16'h0500,Z,  0,0,1,1,16'h00FF,DL},  // 9 R8
    '{8'h1A,1,0,0,1,0,2'd0,0,2'd0,3'd4,3'd0,0,0,16'h0120,DJ, 1,0,0,0,16'h0000,Z },  // 10 R9
    '{8'h1A,1,0,0,1,0,2'd0,0,2'd3,3'd0,3'd0,0,1,16'h0000,Z,  1,0,0,0,16'h0000,Z },  // 11 R9
    '{8'h1A,1,0,0,0,1,2'd0,0,2'd3,3'd1,3'd5,0,0,16'h0000,Z,  1,0,0,0,16'h0000,Z },  // 12 R9
    '{8'h1A,1,0,0,0,0,2'd0,0,2'd0,3'd0,3'd0,0,0,16'h0130,DJ, 1,0,0,0,16'h0000,Z },  // 13 R10
    '{8'h1A,1,0,1,0,1,2'd0,0,2'd0,3'd0,3'd0,0,0,16'h0140,DJ, 1,0,0,0,16'h0000,Z },  // 14 R10
    '{8'h1A,1,0,0,1,0,2'd3,1,2'd0,3'd0,3'd0,0,0,16'h0108,DJ, 0,1,0,0,16'h0000,Z },  // 15 R11
    '{8'h1A,1,0,0,1,0,2'd0,1,2'd0,3'd3,3'd0,0,0,16'h0108,D3, 0,0,1,0,16'hFFFF,Z },  // 16 R11
    '{8'h1A,1,0,0,0,1,2'd3,1,2'd0,3'd0,3'd0,0,0,16'h0404,DJ, 0,1,0,0,16'h0000,Z },  // 17 R11
    '{8'h1A,1,1,0,1,0,2'd3,1,2'd0,3'd0,3'd0,0,0,16'h0104,DJ, 1,0,0,0,16'h0000,Z },  // 18 R11
    '{8'h1B,1,0,0,1,0,2'd0,0,2'd0,3'd0,3'd0,0,0,16'h0230,Z,  0,0,1,1,16'hFFFF,D0},  // 19 R12
    '{8'h1B,1,0,0,1,0,2'd0,0,2'd0,3'd3,3'd0,0,0,16'h0240,Z,  0,0,1,1,16'hFFFF,D3},  // 20 R4
    '{8'h1C,1,0,0,1,0,2'd0,0,2'd3,3'd0,3'd1,0,0,16'h0000,Z,  1,0,0,0,16'h0000,Z },  // 21 R2
    '{8'h1A,0,0,0,1,0,2'd0,0,2'd3,3'd0,3'd1,0,0,16'h0000,Z,  1,0,0,0,16'h0000,Z }   // 22 R2
  };

  function automatic string req_of(input int i);
    case (i)
      0, 20:      return "R4";
      1:          return "R5";
      2, 3:       return "R3";
      4, 5:       return "R6";
      6:          return "R7";
      7, 8, 9:    return "R8";
      10, 11, 12: return "R9";
      13, 14:     return "R10";
      15, 16, 17, 18: return "R11";
      19:         return "R12";
      default:    return "R2";
    endcase
  endfunction

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   in_opcode = '0;
  logic         in_opsz_pfx = 1'b0, in_lock_pfx = 1'b0, in_addr_pfx = 1'b0;
  logic         in_mode64 = 1'b0, in_cs_d = 1'b0, in_ac_en = 1'b0;
  logic [1:0]   in_cpl = '0, in_mod = '0;
  logic [2:0]   in_reg = '0, in_rm = '0;
  logic         in_rex_r = 1'b0, in_rex_b = 1'b0;
  logic [31:0]  in_ea = '0;
  logic         mreq_valid, mreq_we;
  logic         mreq_ready = 1'b0;
  logic [31:0]  mreq_addr;
  logic [15:0]  mreq_be;
  logic [127:0] mreq_wdata;
  logic         mrsp_valid = 1'b0;
  logic [127:0] mrsp_data = '0;
  logic         done_valid, done_ud, done_ac;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bnd_move_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_opsz_pfx(in_opsz_pfx), .in_lock_pfx(in_lock_pfx),
    .in_addr_pfx(in_addr_pfx), .in_mode64(in_mode64), .in_cs_d(in_cs_d),
    .in_cpl(in_cpl), .in_ac_en(in_ac_en), .in_mod(in_mod), .in_reg(in_reg),
    .in_rm(in_rm), .in_rex_r(in_rex_r), .in_rex_b(in_rex_b), .in_ea(in_ea),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_we(mreq_we),
    .mreq_addr(mreq_addr), .mreq_be(mreq_be), .mreq_wdata(mreq_wdata),
    .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data),
    .done_valid(done_valid), .done_ud(done_ud), .done_ac(done_ac)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      summary();
    end
  end

  // Issue one instruction, serve memory with 'stall' cycles of back-pressure
  task automatic run_vec(input vec_t v, input int stall, input string req);
    bit saw = 0, got_done = 0, stable_ok = 1, busy_ok = 1;
    bit ud_c = 0, ac_c = 0, we_c = 0;
    logic [31:0]  addr_c = '0;
    logic [15:0]  be_c = '0;
    logic [127:0] wd_c = '0;
    int waited = 0;
    @(negedge clk);
    in_opcode = v.op; in_opsz_pfx = v.p66; in_lock_pfx = v.lock; in_addr_pfx = v.asz;
    in_mode64 = v.m64; in_cs_d = v.csd; in_cpl = v.cpl; in_ac_en = v.acen;
    in_mod = v.md; in_reg = v.rg; in_rm = v.rm; in_rex_r = v.rexr; in_rex_b = v.rexb;
    in_ea = {16'h0, v.ea};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int cyc = 0; cyc < 40 && !got_done; cyc++) begin
      if (mreq_ready) begin
        mreq_ready = 1'b0;
        if (!we_c) begin mrsp_valid = 1'b1; mrsp_data = v.rdata; end
      end else if (mrsp_valid) begin
        mrsp_valid = 1'b0;
      end
      if (done_valid) begin
        got_done = 1; ud_c = done_ud; ac_c = done_ac;
      end else if (mreq_valid) begin
        if (in_ready) busy_ok = 0;
        if (!saw) begin
          saw = 1; we_c = mreq_we; addr_c = mreq_addr; be_c = mreq_be; wd_c = mreq_wdata;
        end else if (mreq_we !== we_c || mreq_addr !== addr_c ||
                     mreq_be !== be_c || mreq_wdata !== wd_c) begin
          stable_ok = 0;
        end
        if (waited >= stall) mreq_ready = 1'b1;
        else waited++;
      end else if (in_ready && !got_done && saw) begin
        busy_ok = 0;
      end
      if (!got_done) @(negedge clk);
    end
    mrsp_valid = 1'b0;
    mreq_ready = 1'b0;
    chk(got_done, req, "completion seen", 128'(got_done), 128'd1);
    chk(ud_c == v.e_ud, req, "done_ud", 128'(ud_c), 128'(v.e_ud));
    chk(ac_c == v.e_ac, req, "done_ac", 128'(ac_c), 128'(v.e_ac));
    chk(saw == v.e_req, req, "memory request issued", 128'(saw), 128'(v.e_req));
    if (saw && v.e_req) begin
      chk(we_c == v.e_we, req, "mreq_we", 128'(we_c), 128'(v.e_we));
      chk(addr_c == {16'h0, v.ea}, req, "mreq_addr", 128'(addr_c), 128'(v.ea));
      chk(be_c == v.e_be, req, "mreq_be", 128'(be_c), 128'(v.e_be));
      if (v.e_we) chk(wd_c == v.e_wd, req, "mreq_wdata", wd_c, v.e_wd);
    end
    // R13: fields held and unit busy during back-pressure
    if (stall > 0) begin
      chk(stable_ok, "R13", "request fields stable", 128'(stable_ok), 128'd1);
      chk(busy_ok, "R13", "in_ready low while busy", 128'(busy_ok), 128'd1);
    end
  endtask

  task automatic check_idle_after_reset();
    chk(in_ready === 1'b1, "R1", "in_ready after reset", 128'(in_ready), 128'd1);
    chk(mreq_valid === 1'b0, "R1", "mreq_valid after reset", 128'(mreq_valid), 128'd0);
    chk(done_valid === 1'b0, "R1", "done_valid after reset", 128'(done_valid), 128'd0);
  endtask

  function automatic vec_t mk_store(input logic [2:0] r, input logic [15:0] a,
                                    input logic [127:0] wd);
    vec_t s = VECS[1];
    s.rg = r; s.ea = a; s.e_wd = wd;
    return s;
  endfunction

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle_after_reset();                        // R1
    run_vec(mk_store(3'd2, 16'h0600, Z), 0, "R1");   // R1: registers cleared

    for (int i = 0; i < NV; i++) run_vec(VECS[i], (i % 3 == 1) ? 1 : 0, req_of(i));

    // Directed: reset mid-run clears the file (R1)
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle_after_reset();
    run_vec(mk_store(3'd0, 16'h0700, Z), 0, "R1");
    run_vec(mk_store(3'd3, 16'h0710, Z), 0, "R1");

    // Directed: long back-pressure on a 64-bit load and store (R13)
    run_vec(VECS[0], 3, "R13");
    run_vec(mk_store(3'd0, 16'h0720, D0), 4, "R13");

    summary();
  end

endmodule